// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block collects eight maskable interrupt request lines and decides, at each instruction boundary, whether one of them should interrupt the processor. Every source has its own programmable 3-bit level and a fixed rank in a priority chain. A numerically lower level is more urgent. A latched request can only win if its level is strictly below the current priority level (CPL). Software can rewrite the CPL at any time, which raises or lowers the threshold while code is running.

A request pulse sets a pending bit. When the arbitration strobe arrives, the arbiter picks the eligible pending source with the lowest level. A tie goes to the lowest source index. One cycle later the arbiter issues a one-hot grant pulse, a request strobe to the CPU and the registered winner index. The winner's pending bit is cleared by that grant.

A mode input selects how the CPL behaves on a grant. In concurrent mode the CPL is left alone. In nested mode the old CPL is pushed onto a small internal stack and the CPL takes the winner's level. A return strobe pops the stack back into the CPL.

The control sequence has two states:
- `ARB_IDLE`: the arbiter waits here. It moves to `ARB_GRANT` on a winning arbitration and stays in `ARB_IDLE` otherwise.
- `ARB_GRANT`: the grant pulse is presented for one cycle. The arbiter always returns to `ARB_IDLE` on the next cycle.

Top module: `irq_prio_arb`

## Requirements
- R1: A high bit on `req_i` sets the matching bit of `pend_o` on the next cycle. The bit stays set until that source is granted.
- R2: Arbitration happens only when `tick_i` is high in `ARB_IDLE`. A winner produces, one cycle later, a single-cycle `cpu_req_o` pulse and a `grant_o` with only the winner's bit set. `win_idx_o` carries the winner's index and holds it until the next grant. A tick during `ARB_GRANT` is ignored.
- R3: A pending source is eligible only when its level is strictly lower than `cpl_o`. A level equal to or above the CPL is never granted.
- R4: Among eligible sources, the one with the numerically lowest level wins.
- R5: Among eligible sources that share the lowest level, the one with the lowest index wins. Index 0 has the highest chain rank.
- R6: While `ien_i` is low, no grant is issued and all pending bits are kept.
- R7: With `nest_i` low, a grant leaves `cpl_o` unchanged.
- R8: With `nest_i` high, a grant pushes the old CPL onto the stack and loads the winner's level into `cpl_o`.
- R9: `ret_i` pops the most recently saved CPL into `cpl_o`. When the stack is empty, `ret_i` has no effect.
- R10: With `nest_i` high and `STK_DEPTH` saved entries, no grant is issued until a return frees an entry.
- R11: `cpl_wr_i` loads `cpl_data_i` into `cpl_o` on the next cycle. It wins over a nested grant's load in the same cycle.
- R12: A cycle with `ret_i` high performs no arbitration, even when `tick_i` is high.
- R13: If a new request for a source arrives in the same cycle that the source is granted, its pending bit stays set.
- R14: Reset clears all pending bits and the outputs. It sets `cpl_o` to 7, every source level to 7, and empties the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request pulses, one per source |
| lvl_wr_i | input | 1 | Write strobe for a source level |
| lvl_idx_i | input | 3 | Source whose level is written |
| lvl_data_i | input | 3 | New source level |
| cpl_wr_i | input | 1 | Write strobe for the CPL |
| cpl_data_i | input | 3 | New CPL value |
| ien_i | input | 1 | Global enable for maskable grants |
| nest_i | input | 1 | 1 selects nested mode, 0 selects concurrent mode |
| tick_i | input | 1 | Instruction-boundary arbitration strobe |
| ret_i | input | 1 | Return-from-service strobe |
| grant_o | output | 8 | One-hot grant pulse |
| win_idx_o | output | 3 | Registered index of the last winner |
| cpu_req_o | output | 1 | Single-cycle interrupt strobe to the CPU |
| cpl_o | output | 3 | Current priority level |
| pend_o | output | 8 | Pending request bits |

## Verification
Two things can happen to the same bit in the same cycle: a new request on a source can set its pending bit while that source's grant clears it. The bench provokes this by pulsing the winning source's request line in the very cycle that carries the arbitration strobe. It then expects the pending bit to still be set after the grant pulse.

The return strobe and the arbitration strobe can also coincide. In that case the pop must happen and the grant must not. The bench judges every cycle against a behavioural model that uses a queue for the saved levels. Directed sequences fill the stack and also combine a software CPL write with a nested grant.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;
endpackage

// File: rtl/ipa_level_bank.sv
module ipa_level_bank #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 3,
    parameter int IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [LVL_W-1:0]            wr_data,
    output logic [N_SRC-1:0][LVL_W-1:0] levels
);
    // Every source level resets to the least urgent value.
    localparam logic [LVL_W-1:0] LVL_RST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SRC; i++) begin
                levels[i] <= LVL_RST;
            end
        end else if (wr_en) begin
            levels[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/ipa_pending.sv
module ipa_pending #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N_SRC-1:0] pend
);
    logic [N_SRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en) begin
            clr_mask[clr_idx] = 1'b1;
        end
    end

    // A new request wins over the grant's clear when both hit the same bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_mask) | set_i;
        end
    end

    // R1, R13: every incoming request is visible as pending on the next cycle.
    assert_req_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/ipa_select.sv
module ipa_select #(
    parameter int N_SRC = 8,
    parameter int LVL_W = 3,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0]            pend,
    input  logic [N_SRC-1:0][LVL_W-1:0] levels,
    input  logic [LVL_W-1:0]            cpl,
    output logic                        found,
    output logic [IDX_W-1:0]            win_idx,
    output logic [LVL_W-1:0]            win_lvl
);
    // Scan from index 0 upward. A strict less-than compare keeps the earlier
    // (higher chain rank) source when levels tie.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && (levels[i] < cpl) && (!found || (levels[i] < win_lvl))) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = levels[i];
            end
        end
    end
endmodule

// File: rtl/ipa_cpl_stack.sv
module ipa_cpl_stack #(
    parameter int LVL_W     = 3,
    parameter int STK_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_data,
    input  logic             push,
    input  logic [LVL_W-1:0] load_lvl,
    input  logic             pop,
    output logic [LVL_W-1:0] cpl,
    output logic             full
);
    localparam int CNT_W = $clog2(STK_DEPTH + 1);
    localparam int PTR_W = $clog2(STK_DEPTH);
    localparam logic [LVL_W-1:0] CPL_RST = '1;

    logic [LVL_W-1:0] stk [STK_DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top;
    logic             empty;
    logic             do_pop;

    assign full   = (cnt == CNT_W'(STK_DEPTH));
    assign empty  = (cnt == '0);
    assign top    = cnt - CNT_W'(1);
    assign do_pop = pop && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < STK_DEPTH; i++) begin
                stk[i] <= '0;
            end
        end else if (push) begin
            stk[cnt[PTR_W-1:0]] <= cpl;
            cnt <= cnt + CNT_W'(1);
        end else if (do_pop) begin
            cnt <= top;
        end
    end

    // A software write wins over a nested load, which wins over a restore.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpl <= CPL_RST;
        end else if (wr_en) begin
            cpl <= wr_data;
        end else if (push) begin
            cpl <= load_lvl;
        end else if (do_pop) begin
            cpl <= stk[top[PTR_W-1:0]];
        end
    end

    assert_push_not_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_push_pop_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    assert_empty_pop_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !wr_en) |=> $stable(cpl));
    assert_sw_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cpl == $past(wr_data)));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import ipa_pkg::*;
#(
    parameter  int N_SRC     = 8,
    parameter  int LVL_W     = 3,
    parameter  int STK_DEPTH = 4,
    localparam int IDX_W     = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             lvl_wr_i,
    input  logic [IDX_W-1:0] lvl_idx_i,
    input  logic [LVL_W-1:0] lvl_data_i,
    input  logic             cpl_wr_i,
    input  logic [LVL_W-1:0] cpl_data_i,
    input  logic             ien_i,
    input  logic             nest_i,
    input  logic             tick_i,
    input  logic             ret_i,
    output logic [N_SRC-1:0] grant_o,
    output logic [IDX_W-1:0] win_idx_o,
    output logic             cpu_req_o,
    output logic [LVL_W-1:0] cpl_o,
    output logic [N_SRC-1:0] pend_o
);
    localparam logic [N_SRC-1:0] ONE_HOT0 = N_SRC'(1);

    arb_state_e                 st, st_nxt;
    logic [N_SRC-1:0][LVL_W-1:0] levels;
    logic                        found;
    logic [IDX_W-1:0]            win_idx;
    logic [LVL_W-1:0]            win_lvl;
    logic                        stk_full;
    logic                        fire;
    logic                        push;

    ipa_level_bank #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_levels (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lvl_wr_i),
        .wr_idx  (lvl_idx_i),
        .wr_data (lvl_data_i),
        .levels  (levels)
    );

    ipa_pending #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (req_i),
        .clr_en  (fire),
        .clr_idx (win_idx),
        .pend    (pend_o)
    );

    ipa_select #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_sel (
        .pend    (pend_o),
        .levels  (levels),
        .cpl     (cpl_o),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    ipa_cpl_stack #(.LVL_W(LVL_W), .STK_DEPTH(STK_DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpl_wr_i),
        .wr_data  (cpl_data_i),
        .push     (push),
        .load_lvl (win_lvl),
        .pop      (ret_i),
        .cpl      (cpl_o),
        .full     (stk_full)
    );

    // Arbitration is accepted only at a boundary in ARB_IDLE. It is blocked by
    // the enable, by a return strobe, and by a full stack in nested mode.
    assign fire = (st == ARB_IDLE) && tick_i && ien_i && !ret_i && found
                  && !(nest_i && stk_full);
    assign push = fire && nest_i;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ARB_IDLE:  st_nxt = fire ? ARB_GRANT : ARB_IDLE;
            ARB_GRANT: st_nxt = ARB_IDLE;
            default:   st_nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ARB_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o   <= '0;
            cpu_req_o <= 1'b0;
            win_idx_o <= '0;
        end else begin
            grant_o   <= fire ? (ONE_HOT0 << win_idx) : '0;
            cpu_req_o <= fire;
            if (fire) begin
                win_idx_o <= win_idx;
            end
        end
    end

    assert_grant_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |-> (($countones(grant_o) == 1) && grant_o[win_idx_o]));
    assert_grant_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req_o |-> (grant_o == '0));
    assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |=> !cpu_req_o);
    assert_winner_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (pend_o[win_idx] && (win_lvl < cpl_o)));
    assert_disabled_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_i |=> !cpu_req_o);
    assert_concurrent_cpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !nest_i && !cpl_wr_i) |=> $stable(cpl_o));
    assert_nested_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && nest_i && !cpl_wr_i) |=> (cpl_o == $past(win_lvl)));
    assert_ret_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ret_i |=> !cpu_req_o);
endmodule

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 8;
    localparam int STK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       lvl_wr_i = 1'b0;
    logic [2:0] lvl_idx_i = '0;
    logic [2:0] lvl_data_i = '0;
    logic       cpl_wr_i = 1'b0;
    logic [2:0] cpl_data_i = '0;
    logic       ien_i = 1'b0;
    logic       nest_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       ret_i = 1'b0;
    logic [7:0] grant_o;
    logic [2:0] win_idx_o;
    logic       cpu_req_o;
    logic [2:0] cpl_o;
    logic [7:0] pend_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // Behavioural reference state
    int       m_lvl [NS];
    bit [7:0] m_pend;
    int       m_cpl;
    int       m_stk [$];
    bit       m_busy;
    bit [7:0] m_grant;
    int       m_idx;
    bit       m_req;

    irq_prio_arb u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .lvl_wr_i(lvl_wr_i),
        .lvl_idx_i(lvl_idx_i), .lvl_data_i(lvl_data_i), .cpl_wr_i(cpl_wr_i),
        .cpl_data_i(cpl_data_i), .ien_i(ien_i), .nest_i(nest_i), .tick_i(tick_i),
        .ret_i(ret_i), .grant_o(grant_o), .win_idx_o(win_idx_o),
        .cpu_req_o(cpu_req_o), .cpl_o(cpl_o), .pend_o(pend_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        int w;
        int nc;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) m_lvl[i] = 7;
            m_pend = '0; m_cpl = 7; m_stk.delete(); m_busy = 0;
            m_grant = '0; m_idx = 0; m_req = 0;
        end else begin
            w = -1;
            if (!m_busy && tick_i && ien_i && !ret_i && !(nest_i && m_stk.size() == STK)) begin
                for (int i = 0; i < NS; i++) begin
                    if (m_pend[i] && m_lvl[i] < m_cpl && (w < 0 || m_lvl[i] < m_lvl[w])) w = i;
                end
            end
            nc = m_cpl;
            if (w >= 0 && nest_i) begin
                m_stk.push_back(m_cpl);
                nc = m_lvl[w];
            end else if (ret_i && m_stk.size() > 0) begin
                nc = m_stk.pop_back();
            end
            if (cpl_wr_i) nc = int'(cpl_data_i);
            if (w >= 0) m_pend[w] = 1'b0;
            m_pend = m_pend | req_i;
            m_grant = (w >= 0) ? (8'd1 << w) : 8'd0;
            m_req = (w >= 0);
            if (w >= 0) m_idx = w;
            m_busy = (w >= 0);
            if (lvl_wr_i) m_lvl[lvl_idx_i] = int'(lvl_data_i);
            m_cpl = nc;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        chk("R1 R6 R13 pending bits", 32'(pend_o), 32'(m_pend));
        chk("R2 R3 R4 R5 R10 R12 grant vector", 32'(grant_o), 32'(m_grant));
        chk("R2 R6 R12 cpu strobe", 32'(cpu_req_o), 32'(m_req));
        chk("R2 R5 winner index", 32'(win_idx_o), 32'(m_idx));
        chk("R7 R8 R9 R11 current level", 32'(cpl_o), 32'(m_cpl));
    endtask

    // Inputs set before the call are sampled at the next rising edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        req_i = '0; lvl_wr_i = 0; cpl_wr_i = 0; tick_i = 0; ret_i = 0;
    endtask

    task automatic set_lvl(input int idx, input int v);
        lvl_wr_i = 1; lvl_idx_i = 3'(idx); lvl_data_i = 3'(v);
        cyc();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        req_i = '0; lvl_wr_i = 0; cpl_wr_i = 0; tick_i = 0; ret_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R14 reset cpl", 32'(cpl_o), 32'd7);
        chk("R14 reset pending", 32'(pend_o), 32'd0);
        chk("R14 reset strobe", 32'(cpu_req_o), 32'd0);

        set_lvl(0, 5); set_lvl(1, 3); set_lvl(2, 3); set_lvl(3, 6);
        set_lvl(4, 7); set_lvl(5, 2); set_lvl(6, 3); set_lvl(7, 6);
        ien_i = 1;

        // Threshold raised while running: level 6 stays pending at CPL 5.
        cpl_wr_i = 1; cpl_data_i = 5; cyc();
        req_i = 8'h08; cyc();
        chk("R1 pending set", 32'(pend_o[3]), 32'd1);
        tick_i = 1; cyc();
        chk("R3 blocked by cpl 5", 32'(cpu_req_o), 32'd0);
        cpl_wr_i = 1; cpl_data_i = 7; cyc();
        tick_i = 1; cyc();
        chk("R2 strobe", 32'(cpu_req_o), 32'd1);
        chk("R2 index", 32'(win_idx_o), 32'd3);
        chk("R2 one-hot", 32'(grant_o), 32'h08);
        cyc();
        chk("R2 single pulse", 32'(cpu_req_o), 32'd0);
        chk("R1 cleared by grant", 32'(pend_o[3]), 32'd0);
        chk("R7 cpl unchanged", 32'(cpl_o), 32'd7);

        // Equal level is not eligible.
        cpl_wr_i = 1; cpl_data_i = 6; cyc();
        req_i = 8'h80; cyc();
        tick_i = 1; cyc();
        chk("R3 equal level blocked", 32'(cpu_req_o), 32'd0);

        // Global enable off.
        ien_i = 0; req_i = 8'h20; cyc();
        tick_i = 1; cyc();
        chk("R6 no grant", 32'(cpu_req_o), 32'd0);
        chk("R6 pending kept", 32'(pend_o), 32'hA0);
        ien_i = 1; tick_i = 1; cyc();
        chk("R4 lowest level wins", 32'(win_idx_o), 32'd5);
        chk("R7 concurrent cpl", 32'(cpl_o), 32'd6);
        cyc();

        // Tie at level 3, then a tick in the grant state.
        cpl_wr_i = 1; cpl_data_i = 7; req_i = 8'h46; cyc();
        tick_i = 1; cyc();
        chk("R5 tie lowest index", 32'(win_idx_o), 32'd1);
        tick_i = 1; cyc();
        chk("R2 tick ignored while granting", 32'(cpu_req_o), 32'd0);
        chk("R2 pending after busy tick", 32'(pend_o), 32'hC4);

        // Request and grant of the same source in one cycle.
        tick_i = 1; req_i = 8'h04; cyc();
        chk("R13 winner", 32'(win_idx_o), 32'd2);
        chk("R13 pending stays", 32'(pend_o[2]), 32'd1);
        cyc();

        // Nested mode.
        nest_i = 1; tick_i = 1; cyc();
        chk("R8 load level", 32'(cpl_o), 32'd3);
        cyc();
        tick_i = 1; cyc();
        chk("R3 nested threshold", 32'(cpu_req_o), 32'd0);
        req_i = 8'h20; cyc();
        tick_i = 1; cyc();
        chk("R8 second load", 32'(cpl_o), 32'd2);
        cyc();
        ret_i = 1; cyc();
        chk("R9 restore", 32'(cpl_o), 32'd3);
        ret_i = 1; cyc();
        chk("R9 restore base", 32'(cpl_o), 32'd7);
        ret_i = 1; cyc();
        chk("R9 empty return", 32'(cpl_o), 32'd7);

        // Fill the stack.
        do_reset();
        set_lvl(0, 6); set_lvl(1, 5); set_lvl(2, 4); set_lvl(3, 3); set_lvl(4, 2);
        for (int k = 0; k < 4; k++) begin
            req_i = 8'(1 << k); cyc();
            tick_i = 1; cyc();
            chk("R8 stacked load", 32'(cpl_o), 32'(6 - k));
            cyc();
        end
        req_i = 8'h10; cyc();
        tick_i = 1; cyc();
        chk("R10 full blocks", 32'(cpu_req_o), 32'd0);
        ret_i = 1; cyc();
        chk("R9 pop", 32'(cpl_o), 32'd4);
        tick_i = 1; cyc();
        chk("R10 grant after free", 32'(win_idx_o), 32'd4);
        chk("R10 level", 32'(cpl_o), 32'd2);
        cyc();

        // Return and tick together.
        set_lvl(5, 1);
        req_i = 8'h20; cyc();
        tick_i = 1; ret_i = 1; cyc();
        chk("R12 no grant", 32'(cpu_req_o), 32'd0);
        chk("R12 pop done", 32'(cpl_o), 32'd4);
        tick_i = 1; cyc();
        chk("R12 later grant", 32'(win_idx_o), 32'd5);
        cyc();

        // Software write with a nested grant.
        ret_i = 1; cyc();
        set_lvl(6, 0);
        req_i = 8'h40; cyc();
        tick_i = 1; cpl_wr_i = 1; cpl_data_i = 7; cyc();
        chk("R11 grant", 32'(win_idx_o), 32'd6);
        chk("R11 write wins", 32'(cpl_o), 32'd7);
        cyc();

        // Mixed traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            if (n % 500 == 0) nest_i = ~nest_i;
            req_i = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            lvl_wr_i = ($urandom_range(0, 7) == 0);
            lvl_idx_i = 3'($urandom);
            lvl_data_i = 3'($urandom);
            cpl_wr_i = ($urandom_range(0, 15) == 0);
            cpl_data_i = 3'($urandom);
            ien_i = ($urandom_range(0, 7) != 0);
            tick_i = $urandom_range(0, 1) == 1;
            ret_i = ($urandom_range(0, 5) == 0);
            cyc();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule